// File: doc/BRIEF.md
# Tensor Transfer Address Generator

This block copies a two-dimensional rectangle of a tensor from global memory into a local scratchpad without further help from the requester. A requester programs the transfer once: the byte address of the first element, the element counts of the inner and outer dimensions, the byte stride between rows, and the scratchpad start offset. It then issues a single command. The engine takes the command in one handshake, announces the total byte count to a transaction barrier, and then walks the rectangle by itself, emitting read requests of up to 16 bytes each.

Read responses come back in request order. Each response carries the scratchpad offset that its request named, and the engine writes the bytes there. Every write also adds its byte count to the barrier. A waiting consumer is released when the bytes that have arrived match the expected total, so completion does not depend on how many agents took part. In mirrored mode every write goes to a second scratchpad in the same cycle, so one load fills two destinations.

Top module: `tensor_copy_engine`

## Requirements
- R1: After reset `busy` is 0 and `cmd_ready` is 1. `rd_valid`, `sp0_we`, `sp1_we`, `bar_exp_valid` and `bar_add_valid` are all 0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. On the next cycle `bar_exp_valid` pulses for exactly one cycle with `bar_exp_bytes` = (`cmd_cols_m1`+1) × (`cmd_rows_m1`+1) × 2. The count fields use minus-one encoding, and an element is 2 bytes.
- R3: Requests walk the rows in order, starting at row 0. Row r begins at `cmd_base` + r × `cmd_stride`, and the bytes inside a row are contiguous. Every request is 16 bytes long except the last one of a row, which carries the remainder (1 to 16 bytes).
- R4: While `rd_valid` is 1 and `rd_ready` is 0, the request (`rd_addr`, `rd_len`, `rd_off`) is held unchanged into the next cycle.
- R5: `rd_off` of each request is `cmd_spad_base` plus the number of bytes requested before it in the same transfer. Destination offsets are therefore dense.
- R6: One cycle after a response (`rsp_valid`), `sp0_we` is 1, with `sp_addr` = `rsp_off`, `sp_bytes` = `rsp_len` and `sp_data` = `rsp_data`. In the same cycle `bar_add_valid` is 1 with `bar_add_bytes` = `rsp_len`.
- R7: When `cmd_mcast` was 1 at command accept, `sp1_we` equals `sp0_we` for that transfer. Otherwise `sp1_we` stays 0.
- R8: `busy` is 1 from the cycle after accept until the cycle in which the final scratchpad write is presented. While `busy` is 1, `cmd_ready` is 0 and a command offered at that time is not taken: no further `bar_exp_valid` pulse occurs.
- R9: The request count equals the sum of ceil(row bytes / 16) over all rows. No request appears once the last one has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_base | input | 32 | Byte address of the first element |
| cmd_stride | input | 32 | Byte distance between consecutive rows |
| cmd_cols_m1 | input | 8 | Inner dimension element count minus one |
| cmd_rows_m1 | input | 8 | Outer dimension element count minus one |
| cmd_spad_base | input | 16 | Scratchpad byte offset of the first element |
| cmd_mcast | input | 1 | Write to both scratchpads |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 32 | Request byte address |
| rd_len | output | 5 | Request length in bytes (1..16) |
| rd_off | output | 16 | Scratchpad offset to return with the data |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 128 | Response bytes, byte 0 in bits 7:0 |
| rsp_len | input | 5 | Valid bytes in the response |
| rsp_off | input | 16 | Scratchpad offset echoed from the request |
| sp0_we | output | 1 | Primary scratchpad write |
| sp1_we | output | 1 | Mirror scratchpad write |
| sp_addr | output | 16 | Scratchpad byte offset of the write |
| sp_data | output | 128 | Write data |
| sp_bytes | output | 5 | Bytes written |
| bar_exp_valid | output | 1 | Expected byte count announcement |
| bar_exp_bytes | output | 19 | Expected byte total |
| bar_add_valid | output | 1 | Arrived bytes update |
| bar_add_bytes | output | 5 | Bytes arrived |

## Verification
The embedded properties rely on a memory side that behaves. It answers only requests it has accepted, in their order, and returns each request's own length and offset. As a result, a response never reports more bytes than are still outstanding. The bench memory model keeps to this by queueing each accepted request and replying from the head of the queue after at least one cycle. It adds throttling of `rd_ready` and gaps between responses, so the hold behaviour and the end-of-busy timing are both exercised. Commands are offered while the engine is busy only to check that they are refused, and they are withdrawn before the engine goes idle.

// File: rtl/tensor_copy_engine.sv
module tensor_copy_engine #(
  parameter int AW   = 32,
  parameter int SPW  = 16,
  parameter int BEAT = 16,
  parameter int ELEM = 2,
  parameter int DIMW = 8,
  localparam int LENW  = $clog2(BEAT) + 1,
  localparam int ROWBW = DIMW + 1 + $clog2(ELEM),
  localparam int TOTW  = 2 * (DIMW + 1) + $clog2(ELEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [AW-1:0]     cmd_base,
  input  logic [AW-1:0]     cmd_stride,
  input  logic [DIMW-1:0]   cmd_cols_m1,
  input  logic [DIMW-1:0]   cmd_rows_m1,
  input  logic [SPW-1:0]    cmd_spad_base,
  input  logic              cmd_mcast,
  output logic              busy,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [AW-1:0]     rd_addr,
  output logic [LENW-1:0]   rd_len,
  output logic [SPW-1:0]    rd_off,
  input  logic              rsp_valid,
  input  logic [8*BEAT-1:0] rsp_data,
  input  logic [LENW-1:0]   rsp_len,
  input  logic [SPW-1:0]    rsp_off,
  output logic              sp0_we,
  output logic              sp1_we,
  output logic [SPW-1:0]    sp_addr,
  output logic [8*BEAT-1:0] sp_data,
  output logic [LENW-1:0]   sp_bytes,
  output logic              bar_exp_valid,
  output logic [TOTW-1:0]   bar_exp_bytes,
  output logic              bar_add_valid,
  output logic [LENW-1:0]   bar_add_bytes
);

  logic              gen_q, mcast_q, wr_q, exp_v_q;
  logic [AW-1:0]     row_addr_q, stride_q;
  logic [ROWBW-1:0]  col_q, row_bytes_q;
  logic [DIMW-1:0]   row_q, rows_m1_q;
  logic [SPW-1:0]    dst_q, wr_addr_q;
  logic [TOTW-1:0]   remain_q, exp_bytes_q;
  logic [8*BEAT-1:0] wr_data_q;
  logic [LENW-1:0]   wr_len_q;

  wire accept = cmd_valid && cmd_ready;
  wire fire   = gen_q && rd_ready;

  wire [ROWBW-1:0] cmd_row_bytes =
    ROWBW'({1'b0, cmd_cols_m1} + (DIMW+1)'(1)) * ROWBW'(ELEM);
  wire [TOTW-1:0] cmd_total =
    TOTW'(cmd_row_bytes) * TOTW'({1'b0, cmd_rows_m1} + (DIMW+1)'(1));

  wire [ROWBW-1:0] rem_row = row_bytes_q - col_q;
  wire [LENW-1:0]  len     = (rem_row > ROWBW'(BEAT)) ? LENW'(BEAT) : rem_row[LENW-1:0];
  wire             row_end = (col_q + ROWBW'(len)) == row_bytes_q;

  assign busy      = remain_q != '0;
  assign cmd_ready = !busy;
  assign rd_valid  = gen_q;
  assign rd_addr   = row_addr_q + AW'(col_q);
  assign rd_len    = len;
  assign rd_off    = dst_q;

  assign sp0_we        = wr_q;
  assign sp1_we        = wr_q && mcast_q;
  assign sp_addr       = wr_addr_q;
  assign sp_data       = wr_data_q;
  assign sp_bytes      = wr_len_q;
  assign bar_add_valid = wr_q;
  assign bar_add_bytes = wr_len_q;
  assign bar_exp_valid = exp_v_q;
  assign bar_exp_bytes = exp_bytes_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q       <= 1'b0;
      mcast_q     <= 1'b0;
      wr_q        <= 1'b0;
      exp_v_q     <= 1'b0;
      row_addr_q  <= '0;
      stride_q    <= '0;
      col_q       <= '0;
      row_bytes_q <= '0;
      row_q       <= '0;
      rows_m1_q   <= '0;
      dst_q       <= '0;
      remain_q    <= '0;
      exp_bytes_q <= '0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
      wr_len_q    <= '0;
    end else begin
      exp_v_q <= accept;
      if (accept) begin
        gen_q       <= 1'b1;
        mcast_q     <= cmd_mcast;
        row_addr_q  <= cmd_base;
        stride_q    <= cmd_stride;
        col_q       <= '0;
        row_bytes_q <= cmd_row_bytes;
        row_q       <= '0;
        rows_m1_q   <= cmd_rows_m1;
        dst_q       <= cmd_spad_base;
        exp_bytes_q <= cmd_total;
      end else if (fire) begin
        dst_q <= dst_q + SPW'(len);
        if (row_end) begin
          col_q      <= '0;
          row_addr_q <= row_addr_q + stride_q;
          row_q      <= row_q + 1'b1;
          if (row_q == rows_m1_q) gen_q <= 1'b0;
        end else begin
          col_q <= col_q + ROWBW'(len);
        end
      end
      if (accept)         remain_q <= cmd_total;
      else if (rsp_valid) remain_q <= remain_q - TOTW'(rsp_len);
      wr_q <= rsp_valid;
      if (rsp_valid) begin
        wr_addr_q <= rsp_off;
        wr_data_q <= rsp_data;
        wr_len_q  <= rsp_len;
      end
    end
  end

  assert_req_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_len != '0 && rd_len <= LENW'(BEAT)));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(rd_len) && $stable(rd_off)));

  assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (TOTW'(rsp_len) <= remain_q && rsp_len != '0));

  assert_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sp1_we |-> sp0_we);

  assert_exp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bar_exp_valid |=> !bar_exp_valid);

endmodule

// File: tb/tensor_copy_engine_test.sv
module tensor_copy_engine_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, cmd_mcast, busy;
  logic [31:0] cmd_base, cmd_stride;
  logic [7:0] cmd_cols_m1, cmd_rows_m1;
  logic [15:0] cmd_spad_base;
  logic rd_valid, rd_ready, rsp_valid;
  logic [31:0] rd_addr;
  logic [4:0] rd_len, rsp_len, sp_bytes, bar_add_bytes;
  logic [15:0] rd_off, rsp_off, sp_addr;
  logic [127:0] rsp_data, sp_data;
  logic sp0_we, sp1_we, bar_exp_valid, bar_add_valid;
  logic [18:0] bar_exp_bytes;

  tensor_copy_engine uut (.*);

  int nchk = 0, nfail = 0, cyc = 0;
  bit stall_mode = 0, slow_mode = 0;
  logic [31:0] req_addr [2048];
  int req_len [2048];
  int req_off [2048];
  int nreq, nwr, nsp1, nexp, exp_val, add_sum, qhead;
  bit prev_hold;
  logic [31:0] prev_addr;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(posedge clk) cyc++;

  // memory model and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold) begin
        chk(rd_valid === 1'b1 && rd_addr === prev_addr, "R4", "held request address",
            longint'(rd_addr), longint'(prev_addr));
      end
      if (sp0_we) begin
        bit ok = 1;
        if (nwr < nreq) begin
          for (int i = 0; i < req_len[nwr]; i++)
            if (sp_data[8*i +: 8] !== mem_byte(req_addr[nwr] + 32'(i))) ok = 0;
          chk(int'(sp_addr) == req_off[nwr], "R6", "write offset", sp_addr, req_off[nwr]);
          chk(int'(sp_bytes) == req_len[nwr], "R6", "write length", sp_bytes, req_len[nwr]);
          chk(ok, "R6", "write data match", ok, 1);
          chk(bar_add_valid && int'(bar_add_bytes) == req_len[nwr], "R6", "barrier add bytes",
              bar_add_bytes, req_len[nwr]);
        end else chk(0, "R6", "write without request", nwr, nreq);
        add_sum += int'(bar_add_bytes);
        nwr++;
      end
      if (sp1_we) nsp1++;
      if (bar_exp_valid) begin nexp++; exp_val = int'(bar_exp_bytes); end
    end
    rsp_valid = 0;
    if (qhead < nreq && !(slow_mode && cyc % 2 == 0)) begin
      rsp_valid = 1;
      rsp_len   = 5'(req_len[qhead]);
      rsp_off   = 16'(req_off[qhead]);
      rsp_data  = '0;
      for (int i = 0; i < req_len[qhead]; i++)
        rsp_data[8*i +: 8] = mem_byte(req_addr[qhead] + 32'(i));
      qhead++;
    end
    rd_ready = !(stall_mode && cyc % 3 == 1);
    prev_hold = rst_n && rd_valid && !rd_ready;
    prev_addr = rd_addr;
    if (rst_n && rd_valid && rd_ready) begin
      req_addr[nreq] = rd_addr;
      req_len[nreq]  = int'(rd_len);
      req_off[nreq]  = int'(rd_off);
      nreq++;
    end
  end

  task automatic run(input string tag, input logic [31:0] base, input int cols, input int rows,
                     input logic [31:0] stride, input logic [15:0] spb, input bit mc,
                     input bit stl, input bit slw, input bit poke);
    int k, t, rb, off;
    nreq = 0; nwr = 0; nsp1 = 0; nexp = 0; exp_val = 0; add_sum = 0; qhead = 0;
    stall_mode = stl; slow_mode = slw;
    @(negedge clk); #1;
    cmd_base = base; cmd_stride = stride; cmd_cols_m1 = 8'(cols - 1); cmd_rows_m1 = 8'(rows - 1);
    cmd_spad_base = spb; cmd_mcast = mc; cmd_valid = 1;
    chk(cmd_ready === 1'b1, "R2", {tag, " ready before accept"}, cmd_ready, 1);
    @(negedge clk); #1;
    cmd_valid = 0;
    chk(busy === 1'b1, "R8", {tag, " busy after accept"}, busy, 1);
    chk(nexp == 1, "R2", {tag, " expect pulse next cycle"}, nexp, 1);
    t = 0;
    while (busy && t < 20000) begin
      if (poke && t == 2) begin
        cmd_cols_m1 = 8'd3; cmd_rows_m1 = 8'd0; cmd_mcast = ~mc; cmd_valid = 1;
      end
      if (poke && (t == 2 || t == 3))
        chk(cmd_ready === 1'b0, "R8", {tag, " ready low while busy"}, cmd_ready, 0);
      if (poke && t == 4) cmd_valid = 0;
      @(negedge clk); #1;
      t++;
      if (!busy) chk(nwr == nreq && qhead == nreq, "R8", {tag, " busy until last write"}, nwr, nreq);
    end
    chk(!busy, "R8", {tag, " completes"}, busy, 0);
    rb = cols * 2; k = 0; off = int'(spb);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < rb; c += 16) begin
        int l = (rb - c > 16) ? 16 : rb - c;
        logic [31:0] ea = base + 32'(r) * stride + 32'(c);
        if (k < nreq) begin
          chk(req_addr[k] == ea, "R3", {tag, " request address"}, req_addr[k], ea);
          chk(req_len[k] == l, "R3", {tag, " request length"}, req_len[k], l);
          chk(req_off[k] == (off & 16'hFFFF), "R5", {tag, " request offset"}, req_off[k], off & 16'hFFFF);
        end
        off += l; k++;
      end
    chk(nreq == k, "R9", {tag, " request count"}, nreq, k);
    chk(nexp == 1, "R8", {tag, " single expect pulse"}, nexp, 1);
    chk(exp_val == rb * rows, "R2", {tag, " expected bytes"}, exp_val, rb * rows);
    chk(add_sum == rb * rows, "R6", {tag, " arrived bytes total"}, add_sum, rb * rows);
    chk(nsp1 == (mc ? k : 0), "R7", {tag, " mirror writes"}, nsp1, mc ? k : 0);
    repeat (3) begin
      @(negedge clk); #1;
      chk(!rd_valid && !sp0_we, "R9", {tag, " quiet after done"}, rd_valid, 0);
    end
  endtask

  task automatic t_reset;
    chk(busy === 1'b0, "R1", "busy at reset", busy, 0);
    chk(cmd_ready === 1'b1, "R1", "ready at reset", cmd_ready, 1);
    chk(!rd_valid && !sp0_we && !sp1_we, "R1", "no request or write at reset", rd_valid, 0);
    chk(!bar_exp_valid && !bar_add_valid, "R1", "no barrier traffic at reset", bar_exp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_base = 0; cmd_stride = 0; cmd_cols_m1 = 0; cmd_rows_m1 = 0;
    cmd_spad_base = 0; cmd_mcast = 0; rd_ready = 1; rsp_valid = 0; rsp_len = 0; rsp_off = 0; rsp_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    t_reset();
    run("one full beat",   32'h1000, 8,   1, 32'd0,    16'h0100, 0, 0, 0, 0);
    run("row remainder",   32'h2002, 13,  3, 32'd100,  16'h0040, 0, 0, 1, 0);
    run("max width stall", 32'h8000, 256, 2, 32'd1024, 16'h0000, 0, 1, 0, 0);
    run("mirrored",        32'h3000, 20,  4, 32'd64,   16'h0200, 1, 1, 1, 0);
    run("busy refusal",    32'h4010, 40,  3, 32'd96,   16'h1000, 0, 0, 1, 1);
    run("single element",  32'h5005, 1,   1, 32'd0,    16'hFFFE, 0, 0, 0, 0);
    run("tall narrow",     32'h6000, 3,  40, 32'd8,    16'hFFF0, 1, 1, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule